// File: doc/BRIEF.md
# Normalization Exponent Detector

This block looks at a 16-bit two's-complement word and works out how far it would have to move left so that its last sign bit sits in the top position. It stores the negated distance in a signed exponent register. A later normalize shift reads that register. For a double-precision value the block is used twice in a row. The first pass looks at the upper half and sets the exponent. The second pass looks at the lower half and changes the exponent only when the upper half held nothing but sign bits. In that case the count carries on into the lower word.

A third mode handles ALU results that may have overflowed. When the overflow flag is set, the exponent becomes +1. The following shift then moves the value right by one place and can put the carry back in as the true sign. When the flag is clear, this mode acts exactly like the plain upper-half pass. For denormalize, the exponent register can also be written directly from an outside value.

Mode codes on `mode`: 2'b00 upper/single pass, 2'b01 lower pass, 2'b10 overflow-aware pass, 2'b11 reserved.

Top module: `exp_detect`

## Requirements
- R1: After reset, `exp_q` is 0 and `hi_sign_q` is 0.
- R2: When `load` is high with mode 2'b00, `exp_q` becomes the negated number of bits below the MSB that equal the MSB. For example, 0xF6D4 gives -3, 0x4000 gives 0 and 0x0001 gives -14.
- R3: When the mode 2'b00 pass sees a word made only of sign bits (0xFFFF or 0x0000), `exp_q` becomes -15.
- R4: A mode 2'b01 pass leaves `exp_q` unchanged unless `exp_q` holds -15 at that moment. For example, 0xF6D4 followed by 0x6ECB stays at -3.
- R5: When `exp_q` is -15, a mode 2'b01 pass loads -15 minus the number of leading bits of the lower word that equal `hi_sign_q`. The lower word's own MSB plays no part. For example, 0xFFFF then 0xF6D4 gives -19, 0x0000 then 0x0000 gives -31, and 0xFFFF then 0x7FFF gives -15.
- R6: With mode 2'b10 and `ovf` high, `exp_q` becomes +1 whatever the value of `carry` or the data word.
- R7: With mode 2'b10 and `ovf` low, the result is the same as a mode 2'b00 pass and `carry` is ignored. For example, 0xE35B gives -2.
- R8: A mode 2'b00 or 2'b10 pass copies the MSB of the data word into `hi_sign_q`. A mode 2'b01 pass leaves `hi_sign_q` alone.
- R9: `ext_load` writes `ext_val` into `exp_q` on the next edge. It takes priority over `load`, and `hi_sign_q` is not changed in that cycle.
- R10: With neither strobe high, or with `load` high and mode 2'b11, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Run a detection pass this cycle |
| mode | input | 2 | Pass type (00 upper, 01 lower, 10 overflow-aware) |
| din | input | 16 | Data word to examine |
| ovf | input | 1 | ALU overflow flag |
| carry | input | 1 | ALU carry flag (true sign when overflowed) |
| ext_load | input | 1 | Load the exponent directly |
| ext_val | input | 8 | Signed exponent value for direct load |
| exp_q | output | 8 | Signed exponent register |
| hi_sign_q | output | 1 | Sign captured by the last upper pass |

## Verification
The bench builds the block with its default parameters: a 16-bit word and an 8-bit exponent. With these values every count from -31 to +1 can be reached, including a lower pass that matches all 16 bits. The vector table chains upper and lower passes so that the lower pass sees both the -15 and the non -15 cases. It includes a lower word whose MSB differs from the captured sign. It also places a direct load onto -15 just before a lower pass, which shows that the refinement depends only on the register value.

// File: rtl/exp_detect.sv
module exp_detect #(
  parameter int DW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] din,
  input  logic          ovf,
  input  logic          carry,
  input  logic          ext_load,
  input  logic [EW-1:0] ext_val,
  output logic [EW-1:0] exp_q,
  output logic          hi_sign_q
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [1:0] M_HI  = 2'b00;
  localparam logic [1:0] M_LO  = 2'b01;
  localparam logic [1:0] M_HIX = 2'b10;
  localparam logic [EW-1:0] ALL_SIGN = EW'(-(DW - 1));
  localparam logic [EW-1:0] PLUS_ONE = EW'(1);

  function automatic logic [CW-1:0] run_len(input logic [DW-1:0] v, input logic s);
    logic [CW-1:0] n;
    logic          run;
    n   = '0;
    run = 1'b1;
    for (int i = DW - 1; i >= 0; i--) begin
      if (run && (v[i] == s)) n = n + 1'b1;
      else run = 1'b0;
    end
    return n;
  endfunction

  logic [CW-1:0] hi_cnt, lo_cnt;
  logic [EW-1:0] hi_exp, lo_exp, nxt_exp;
  logic          nxt_sign;

  // The appended inverted sign bit caps the upper count at DW-1.
  assign hi_cnt = run_len({din[DW-2:0], ~din[DW-1]}, din[DW-1]);
  assign lo_cnt = run_len(din, hi_sign_q);
  assign hi_exp = EW'(0) - EW'(hi_cnt);
  assign lo_exp = ALL_SIGN - EW'(lo_cnt);

  always_comb begin
    nxt_exp  = exp_q;
    nxt_sign = hi_sign_q;
    if (ext_load) begin
      nxt_exp = ext_val;
    end else if (load) begin
      unique case (mode)
        M_HI: begin
          nxt_exp  = hi_exp;
          nxt_sign = din[DW-1];
        end
        M_HIX: begin
          nxt_exp  = ovf ? PLUS_ONE : hi_exp;
          nxt_sign = din[DW-1];
        end
        M_LO: begin
          if (exp_q == ALL_SIGN) nxt_exp = lo_exp;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q     <= '0;
      hi_sign_q <= 1'b0;
    end else begin
      exp_q     <= nxt_exp;
      hi_sign_q <= nxt_sign;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !ext_load) |=> ($stable(exp_q) && $stable(hi_sign_q)));

  p_lo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ext_load && mode == M_LO && exp_q != ALL_SIGN) |=> $stable(exp_q));

  p_lo_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == M_LO) |=> $stable(hi_sign_q));

  p_ovf_plus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ext_load && mode == M_HIX && ovf) |=> (exp_q == PLUS_ONE));

  p_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_load |=> (exp_q == $past(ext_val) && $stable(hi_sign_q)));
endmodule

// File: tb/exp_detect_tb.sv
module exp_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] din = '0;
  logic        ovf = 1'b0;
  logic        carry = 1'b0;
  logic        ext_load = 1'b0;
  logic [7:0]  ext_val = '0;
  logic [7:0]  exp_q;
  logic        hi_sign_q;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  exp_detect u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode), .din(din),
    .ovf(ovf), .carry(carry), .ext_load(ext_load), .ext_val(ext_val),
    .exp_q(exp_q), .hi_sign_q(hi_sign_q)
  );

  // {ext_load, load, mode, din, ovf, carry, ext_val, exp expected, sign expected, req}
  localparam int NV = 22;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0,1'b1,2'd0,16'hF6D4,1'b0,1'b0,8'h00,8'hFD,1'b1,8'd2},  // R2
    {1'b0,1'b1,2'd1,16'h6ECB,1'b0,1'b0,8'h00,8'hFD,1'b1,8'd4},  // R4
    {1'b0,1'b1,2'd0,16'hFFFF,1'b0,1'b0,8'h00,8'hF1,1'b1,8'd3},  // R3
    {1'b0,1'b1,2'd1,16'hF6D4,1'b0,1'b0,8'h00,8'hED,1'b1,8'd5},  // R5
    {1'b0,1'b1,2'd0,16'h0000,1'b0,1'b0,8'h00,8'hF1,1'b0,8'd3},  // R3
    {1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,8'h00,8'hE1,1'b0,8'd5},  // R5
    {1'b0,1'b1,2'd0,16'h0000,1'b0,1'b0,8'h00,8'hF1,1'b0,8'd8},  // R8
    {1'b0,1'b1,2'd1,16'h0FFF,1'b0,1'b0,8'h00,8'hED,1'b0,8'd5},  // R5
    {1'b0,1'b1,2'd0,16'hFFFF,1'b0,1'b0,8'h00,8'hF1,1'b1,8'd8},  // R8
    {1'b0,1'b1,2'd1,16'h7FFF,1'b0,1'b0,8'h00,8'hF1,1'b1,8'd5},  // R5
    {1'b0,1'b1,2'd2,16'hFA32,1'b1,1'b0,8'h00,8'h01,1'b1,8'd6},  // R6
    {1'b0,1'b1,2'd2,16'h0A32,1'b1,1'b1,8'h00,8'h01,1'b0,8'd6},  // R6
    {1'b0,1'b1,2'd2,16'hE35B,1'b0,1'b1,8'h00,8'hFE,1'b1,8'd7},  // R7
    {1'b0,1'b1,2'd0,16'h4000,1'b0,1'b0,8'h00,8'h00,1'b0,8'd2},  // R2
    {1'b0,1'b1,2'd0,16'h0001,1'b0,1'b0,8'h00,8'hF2,1'b0,8'd2},  // R2
    {1'b0,1'b1,2'd1,16'h1234,1'b0,1'b0,8'h00,8'hF2,1'b0,8'd4},  // R4
    {1'b0,1'b0,2'd0,16'hFFFF,1'b0,1'b0,8'h00,8'hF2,1'b0,8'd10}, // R10
    {1'b0,1'b1,2'd3,16'hFFFF,1'b1,1'b1,8'h00,8'hF2,1'b0,8'd10}, // R10
    {1'b1,1'b0,2'd0,16'h0000,1'b0,1'b0,8'h05,8'h05,1'b0,8'd9},  // R9
    {1'b1,1'b1,2'd0,16'hF6D4,1'b0,1'b0,8'hF0,8'hF0,1'b0,8'd9},  // R9
    {1'b0,1'b1,2'd1,16'h0000,1'b0,1'b0,8'h00,8'hF0,1'b0,8'd4},  // R4
    {1'b1,1'b0,2'd0,16'h0000,1'b0,1'b0,8'hF1,8'hF1,1'b0,8'd9}   // R9
  };

  task automatic check(input string tag, input logic [7:0] ee, input logic es);
    n_chk++;
    if (exp_q !== ee || hi_sign_q !== es) begin
      n_bad++;
      $display("FAIL %s: exp=%h sign=%b expected exp=%h sign=%b", tag, exp_q, hi_sign_q, ee, es);
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 8'h00, 1'b0);
    for (int i = 0; i < NV; i++) begin
      {ext_load, load, mode, din, ovf, carry, ext_val} = VEC[i][46:17];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][16:9], VEC[i][8]);
    end
    // R5: lower pass after a direct load of -15, captured sign 0, word 0xFFFF
    ext_load = 1'b0; load = 1'b1; mode = 2'd1; din = 16'hFFFF;
    @(negedge clk);
    check("R5 after direct -15", 8'hF1, 1'b0);
    // R5: all 16 lower bits match captured sign 0
    din = 16'h0000;
    @(negedge clk);
    check("R5 full lower run", 8'hE1, 1'b0);
    // R1: reset mid-run clears both registers
    mode = 2'd0; din = 16'hFFFF;
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hold after reset", 8'h00, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule